// File: doc/BRIEF.md
# Round-Robin Multi-Stream Event Builder

This block builds one event at a time out of several per-stream FIFOs. It drives a stream address over the FIFOs and visits each stream in turn, starting from stream 0. A stream that reports itself disabled is passed over. An enabled stream is drained word by word until it delivers a word carrying the end-of-sub-event mark. There is no time limit on that wait. Once the last stream has been visited the event is complete.

Each consumed stream word is packed in raw form and written to an output page. The body starts at offset 4. When the body is finished, the block writes a four-word header at offsets 0 to 3. The header holds the word count, an error flag, the running error count and a 32-bit event number.

A page manager supplies a page-free indication. It receives a start pulse when a page is claimed and a done pulse when the page holds a complete event. In the sample-all mode, a readout waits for a free page. Otherwise the FIFOs are drained at full speed, and an event is stored only when a page was free at its start.

Top module: `stream_event_builder`

## Requirements
- R1: While idle, a new event readout begins only in a cycle where `rdo_en` is 1 (and the R9 condition holds). Lowering `rdo_en` later does not stop an event that has already begun.
- R2: When the addressed stream has `strm_enabled` at 0, `rd_req` stays 0 and the address moves on in the next cycle. Nothing is read from that stream.
- R3: For an enabled stream, `rd_req` stays at 1. A word is consumed in each cycle where `rd_req` and `strm_valid` are both 1. The block waits on that stream for as long as needed, and it leaves the stream after consuming a word with bit 8 set.
- R4: Every event visits streams 0 to NUM_STREAMS-1 in increasing order, taking exactly one sub-event from each enabled stream. The header is written after the last stream.
- R5: Body words go to consecutive offsets starting at 4, in consumption order. Each body word is {3'b000, stream number in bits 12:9, end-of-sub-event flag in bit 8, data byte in bits 7:0}.
- R6: Header word 0 (offset 0) has bit 15 = 0 and bit 14 = the event's error flag. Bits 13:0 hold the number of stored words including the header, saturating at 2^CNT_W-1.
- R7: Header word 1 (offset 1) is the count of events with the error flag set since reset, including the current event. Words 2 and 3 are the low and high halves of a 32-bit count of events drained since reset, including the current event. The first event after reset carries 1.
- R8: A body word that would land at offset PAGE_WORDS or beyond is not written. It sets the event's error flag, and that in turn raises the error count.
- R9: With `sample_all` = 1, no readout begins (and `rd_req` stays 0) while `page_free` is 0.
- R10: With `sample_all` = 0, a readout begins regardless of `page_free`. The event is stored only if `page_free` was 1 at its start. An unstored event is fully drained and counted, but it produces no writes and no start or done pulses.
- R11: For a stored event, `evt_start` pulses for one cycle at the start. `evt_done` pulses for one cycle, in the cycle directly after the write of header word 3.
- R12: Reset returns the address to 0 and clears both counters. It also abandons any partly built event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous module reset |
| rdo_en | input | 1 | Global readout enable |
| sample_all | input | 1 | 1: start an event only when a page is free |
| page_free | input | 1 | Page manager has a free page |
| stream_addr | output | ADDR_W | Address of the stream being interrogated |
| rd_req | output | 1 | Word request to the addressed stream |
| strm_enabled | input | 1 | Addressed stream is enabled |
| strm_valid | input | 1 | Addressed stream presents a word |
| strm_data | input | 9 | Stream word; bit 8 marks end of sub-event |
| out_we | output | 1 | Page write strobe |
| out_addr | output | OFS_W | Word offset in the page (log2 of PAGE_WORDS) |
| out_data | output | 16 | Page write data |
| evt_start | output | 1 | Pulse: a stored event claims a page |
| evt_done | output | 1 | Pulse: the page holds a complete event |

## Verification
The bench builds the block with four streams, a 20-word page and a 4-bit word-count field. This makes all sixteen enable masks cheap to sweep, with the sub-event lengths varied per mask and stalls on the valid line. The small field and page also let short events reach word-count saturation and page overflow. The blocking wait, both sampling modes and a reset in the middle of an event are driven directly, and the header fields are recomputed from the loaded stream contents.

// File: rtl/seb_pkg.sv
package seb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HDR  = 2'd2,
    ST_DONE = 2'd3
  } seb_state_e;

  localparam int HDR_WORDS = 4;

  // Raw body word: zero top bits, stream id, end flag, byte.
  function automatic logic [15:0] raw_word(input logic [3:0] sid, input logic [8:0] d);
    return {3'b000, sid, d};
  endfunction

  // Header word 0: clear top bit, error flag, word count.
  function automatic logic [15:0] count_word(input logic err, input logic [13:0] cnt);
    return {1'b0, err, cnt};
  endfunction

endpackage

// File: rtl/seb_scan_ctrl.sv
module seb_scan_ctrl
  import seb_pkg::*;
#(
  parameter int NUM_STREAMS = 12,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdo_en,
  input  logic              sample_all,
  input  logic              page_free,
  input  logic              strm_enabled,
  input  logic              strm_valid,
  input  logic              strm_eos,
  output logic [ADDR_W-1:0] stream_addr,
  output logic              rd_req,
  output seb_state_e        state,
  output logic [1:0]        hdr_idx,
  output logic              stored,
  output logic              ev_begin,
  output logic              take,
  output logic              scan_end,
  output logic              evt_start,
  output logic              evt_done
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_STREAMS - 1);

  logic go, adv, at_last;

  assign go        = (state == ST_IDLE) && rdo_en && (!sample_all || page_free);
  assign ev_begin  = go;
  assign evt_start = go && page_free;
  assign rd_req    = (state == ST_SCAN) && strm_enabled;
  assign take      = rd_req && strm_valid;
  assign adv       = (state == ST_SCAN) && (!strm_enabled || (take && strm_eos));
  assign at_last   = (stream_addr == LAST);
  assign scan_end  = adv && at_last;
  assign evt_done  = (state == ST_DONE) && stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      stream_addr <= '0;
      stored      <= 1'b0;
      hdr_idx     <= 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          state       <= ST_SCAN;
          stream_addr <= '0;
          stored      <= page_free;
        end
        ST_SCAN: if (adv) begin
          if (at_last) begin
            state   <= ST_HDR;
            hdr_idx <= 2'd0;
          end else begin
            stream_addr <= stream_addr + 1'b1;
          end
        end
        ST_HDR: begin
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd3) state <= ST_DONE;
        end
        ST_DONE: begin
          state       <= ST_IDLE;
          stream_addr <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: an idle builder without enable stays idle
  assert_idle_without_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rdo_en) |=> (state == ST_IDLE));

  // R2: a disabled stream is passed in one cycle
  assert_skip_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN && !strm_enabled && !at_last) |=>
      (stream_addr == ADDR_W'($past(stream_addr) + 1'b1)));

  // R3: with no word available the block keeps waiting on the same stream
  assert_hold_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !strm_valid) |=> (state == ST_SCAN && $stable(stream_addr)));

  // R4: each readout begins at stream 0
  assert_start_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_begin |=> (stream_addr == '0 && state == ST_SCAN));

  // R9: no request while waiting for a page in sample-all mode
  assert_sample_all_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sample_all && !page_free) |=> !rd_req);

endmodule

// File: rtl/seb_word_track.sv
module seb_word_track
  import seb_pkg::*;
#(
  parameter int PAGE_WORDS = 16384,
  parameter int CNT_W      = 14,
  parameter int POS_W      = $clog2(PAGE_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_begin,
  input  logic             take,
  output logic [POS_W-1:0] pos,
  output logic             wr_ok,
  output logic             evt_err,
  output logic             err_final,
  output logic [CNT_W-1:0] word_count
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic room;

  function automatic logic [CNT_W-1:0] sat_count(input logic [POS_W-1:0] p);
    if (int'(p) > CNT_MAX) return CNT_W'(CNT_MAX);
    return CNT_W'(p);
  endfunction

  assign room       = (int'(pos) < PAGE_WORDS);
  assign wr_ok      = take && room;
  assign err_final  = evt_err || (take && !room);
  assign word_count = sat_count(pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= POS_W'(HDR_WORDS);
      evt_err <= 1'b0;
    end else if (ev_begin) begin
      pos     <= POS_W'(HDR_WORDS);
      evt_err <= 1'b0;
    end else if (take) begin
      if (room) pos     <= pos + 1'b1;
      else      evt_err <= 1'b1;
    end
  end

  // R8: the write position never passes the page end
  assert_pos_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) <= PAGE_WORDS);

  // R8: a dropped word marks the event as erroneous
  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !room && !ev_begin) |=> evt_err);

endmodule

// File: rtl/seb_event_count.sv
module seb_event_count #(
  parameter int EVC_W  = 32,
  parameter int ERRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_end,
  input  logic              err_final,
  output logic [EVC_W-1:0]  ev_cnt,
  output logic [ERRC_W-1:0] err_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt  <= '0;
      err_cnt <= '0;
    end else if (scan_end) begin
      ev_cnt <= ev_cnt + 1'b1;
      if (err_final) err_cnt <= err_cnt + 1'b1;
    end
  end

  // R7: each drained event advances the event number by one
  assert_event_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |=> (ev_cnt == $past(ev_cnt) + 1'b1));

  // R7: the error count moves only at the end of an event
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_end |=> $stable(err_cnt));

endmodule

// File: rtl/stream_event_builder.sv
module stream_event_builder
  import seb_pkg::*;
#(
  parameter int NUM_STREAMS = 12,
  parameter int ADDR_W      = 4,
  parameter int PAGE_WORDS  = 16384,
  parameter int CNT_W       = 14,
  localparam int OFS_W      = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdo_en,
  input  logic              sample_all,
  input  logic              page_free,
  output logic [ADDR_W-1:0] stream_addr,
  output logic              rd_req,
  input  logic              strm_enabled,
  input  logic              strm_valid,
  input  logic [8:0]        strm_data,
  output logic              out_we,
  output logic [OFS_W-1:0]  out_addr,
  output logic [15:0]       out_data,
  output logic              evt_start,
  output logic              evt_done
);

  localparam int POS_W  = $clog2(PAGE_WORDS + 1);
  localparam int EVC_W  = 32;
  localparam int ERRC_W = 16;

  seb_state_e        state;
  logic [1:0]        hdr_idx;
  logic              stored, ev_begin, take, scan_end;
  logic [POS_W-1:0]  pos;
  logic              wr_ok, evt_err, err_final;
  logic [CNT_W-1:0]  word_count;
  logic [EVC_W-1:0]  ev_cnt;
  logic [ERRC_W-1:0] err_cnt;

  seb_scan_ctrl #(.NUM_STREAMS(NUM_STREAMS), .ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .rdo_en(rdo_en), .sample_all(sample_all),
    .page_free(page_free), .strm_enabled(strm_enabled), .strm_valid(strm_valid),
    .strm_eos(strm_data[8]), .stream_addr(stream_addr), .rd_req(rd_req),
    .state(state), .hdr_idx(hdr_idx), .stored(stored), .ev_begin(ev_begin),
    .take(take), .scan_end(scan_end), .evt_start(evt_start), .evt_done(evt_done)
  );

  seb_word_track #(.PAGE_WORDS(PAGE_WORDS), .CNT_W(CNT_W), .POS_W(POS_W)) u_track (
    .clk(clk), .rst_n(rst_n), .ev_begin(ev_begin), .take(take), .pos(pos),
    .wr_ok(wr_ok), .evt_err(evt_err), .err_final(err_final), .word_count(word_count)
  );

  seb_event_count #(.EVC_W(EVC_W), .ERRC_W(ERRC_W)) u_count (
    .clk(clk), .rst_n(rst_n), .scan_end(scan_end), .err_final(err_final),
    .ev_cnt(ev_cnt), .err_cnt(err_cnt)
  );

  always_comb begin
    out_we   = 1'b0;
    out_addr = '0;
    out_data = '0;
    if (state == ST_SCAN) begin
      out_we   = wr_ok && stored;
      out_addr = pos[OFS_W-1:0];
      out_data = raw_word(4'(stream_addr), strm_data);
    end else if (state == ST_HDR) begin
      out_we   = stored;
      out_addr = OFS_W'(hdr_idx);
      unique case (hdr_idx)
        2'd0: out_data = count_word(evt_err, 14'(word_count));
        2'd1: out_data = err_cnt;
        2'd2: out_data = ev_cnt[15:0];
        default: out_data = ev_cnt[31:16];
      endcase
    end
  end

  // R5: body words never land in the header area
  assert_body_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && state == ST_SCAN) |-> (int'(out_addr) >= HDR_WORDS));

  // R10: an unstored event writes nothing
  assert_unstored_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !stored) |-> (!out_we && !evt_done));

  // R11: done follows the last header write directly
  assert_done_after_header_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> ($past(out_we) && $past(out_addr) == OFS_W'(3)));

endmodule

// File: tb/stream_event_builder_bench.sv
`timescale 1ns/100ps
module stream_event_builder_bench;

  localparam int NS   = 4;
  localparam int PW   = 20;
  localparam int CW   = 4;
  localparam int OW   = $clog2(PW);
  localparam int MAXW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rdo_en, sample_all, page_free;
  logic [3:0] stream_addr;
  logic rd_req, strm_enabled, strm_valid;
  logic [8:0] strm_data;
  logic out_we, evt_start, evt_done;
  logic [OW-1:0] out_addr;
  logic [15:0] out_data;

  stream_event_builder #(.NUM_STREAMS(NS), .ADDR_W(4), .PAGE_WORDS(PW), .CNT_W(CW)) u_stream_event_builder (
    .clk(clk), .rst_n(rst_n), .rdo_en(rdo_en), .sample_all(sample_all), .page_free(page_free),
    .stream_addr(stream_addr), .rd_req(rd_req), .strm_enabled(strm_enabled),
    .strm_valid(strm_valid), .strm_data(strm_data), .out_we(out_we), .out_addr(out_addr),
    .out_data(out_data), .evt_start(evt_start), .evt_done(evt_done)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stream FIFO model, show-ahead
  logic [8:0] fdat [NS][MAXW];
  int flen [NS];
  int fptr [NS];
  logic [NS-1:0] en_mask = '0;
  bit stall_on = 0, phase = 0;

  always_comb begin
    int a;
    a = int'(stream_addr);
    strm_enabled = 1'b0;
    strm_valid   = 1'b0;
    strm_data    = '0;
    if (a < NS) begin
      strm_enabled = en_mask[a];
      strm_valid   = (fptr[a] < flen[a]) && !(stall_on && phase);
      if (fptr[a] < MAXW) strm_data = fdat[a][fptr[a]];
    end
  end

  always @(posedge clk) begin : fifo_pop
    int ia;
    ia = int'(stream_addr);
    phase <= ~phase;
    if (rd_req && strm_valid && ia < NS) fptr[ia] <= fptr[ia] + 1;
  end

  // output capture at the falling edge
  logic [15:0] page [PW];
  int wr_cnt = 0, st_cnt = 0, dn_cnt = 0, rdq_cnt = 0;
  bit prev_w3 = 0, done_ok = 0;

  always @(negedge clk) begin
    if (out_we) begin
      wr_cnt++;
      if (int'(out_addr) < PW) page[int'(out_addr)] = out_data;
    end
    if (evt_start) st_cnt++;
    if (evt_done) begin
      dn_cnt++;
      done_ok = prev_w3;
    end
    if (rd_req) rdq_cnt++;
    prev_w3 = out_we && (out_addr == OW'(3));
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  longint exp_ev = 0, exp_err = 0;

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic load(input logic [NS-1:0] m, input int seed, input int maxlen);
    en_mask = m;
    for (int s = 0; s < NS; s++) begin
      flen[s] = 1 + ((s * 3 + seed) % maxlen);
      fptr[s] = 0;
      for (int i = 0; i < MAXW; i++)
        fdat[s][i] = {(i == flen[s] - 1), 8'((s * 37 + i * 11 + seed * 5) & 255)};
    end
  endtask

  task automatic clear_capture();
    wr_cnt = 0; st_cnt = 0; dn_cnt = 0; rdq_cnt = 0; done_ok = 0;
    for (int i = 0; i < PW; i++) page[i] = 16'hBEEF;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000 && dn_cnt == 0; k++) step();
    step(2);
  endtask

  // checks the stored page against the loaded streams
  task automatic expect_event(input string tag);
    int nbody, total, stored, cnt, pos, bad, undrained;
    bit ovf;
    logic [15:0] w;
    logic [15:0] first_bad_act, first_bad_exp;
    nbody = 0;
    for (int s = 0; s < NS; s++) if (en_mask[s]) nbody += flen[s];
    total  = 4 + nbody;
    ovf    = total > PW;
    stored = ovf ? PW : total;
    cnt    = (stored > CMAX) ? CMAX : stored;
    exp_ev++;
    if (ovf) exp_err++;
    w = {1'b0, ovf, 14'(cnt)};
    chk(page[0] === w, {tag, " R6 header word0"}, page[0], w);
    if (ovf) chk(page[0][14] === 1'b1, {tag, " R8 overflow flag"}, page[0], w);
    chk(page[1] === 16'(exp_err), {tag, " R7 error count"}, page[1], exp_err);
    chk(page[2] === 16'(exp_ev), {tag, " R7 event count low"}, page[2], exp_ev);
    chk(page[3] === 16'(exp_ev >> 16), {tag, " R7 event count high"}, page[3], 0);
    pos = 4; bad = 0; first_bad_act = 0; first_bad_exp = 0;
    for (int s = 0; s < NS; s++) begin
      if (en_mask[s]) begin
        for (int i = 0; i < flen[s]; i++) begin
          if (pos < PW) begin
            w = {3'b000, 4'(s), fdat[s][i]};
            if (page[pos] !== w) begin
              if (bad == 0) begin first_bad_act = page[pos]; first_bad_exp = w; end
              bad++;
            end
          end
          pos++;
        end
      end
    end
    chk(bad == 0, {tag, " R5 body words in order"}, first_bad_act, first_bad_exp);
    chk(wr_cnt == stored, {tag, " R8 write count"}, wr_cnt, stored);
    undrained = 0;
    for (int s = 0; s < NS; s++)
      if (fptr[s] != (en_mask[s] ? flen[s] : 0)) undrained++;
    chk(undrained == 0, {tag, " R2 R4 one sub-event per enabled stream"}, undrained, 0);
    chk(st_cnt == 1 && dn_cnt == 1, {tag, " R11 one start one done"}, st_cnt * 16 + dn_cnt, 17);
    chk(done_ok, {tag, " R11 done after header word 3"}, done_ok, 1);
  endtask

  task automatic run_stored(input logic [NS-1:0] m, input int seed, input int maxlen,
                            input bit stall, input string tag);
    load(m, seed, maxlen);
    stall_on = stall;
    clear_capture();
    rdo_en = 1'b1;
    step();
    rdo_en = 1'b0;
    wait_done();
    expect_event(tag);
  endtask

  initial begin
    rst_n = 1'b0; rdo_en = 1'b0; sample_all = 1'b0; page_free = 1'b1;
    for (int s = 0; s < NS; s++) begin flen[s] = 0; fptr[s] = 0; end
    clear_capture();
    step(3);
    // R12: reset state
    chk(stream_addr == 4'd0, "R12 reset address", stream_addr, 0);
    chk(!rd_req && !out_we && !evt_done, "R12 reset outputs quiet", {rd_req, out_we, evt_done}, 0);
    rst_n = 1'b1;

    // R1: nothing happens without rdo_en
    load(4'b1111, 0, 3);
    clear_capture();
    step(20);
    chk(rdq_cnt == 0 && st_cnt == 0, "R1 idle without enable", rdq_cnt + st_cnt, 0);

    // R4 R5 R6 R7: sweep of all enable masks
    for (int m = 0; m < 16; m++)
      run_stored(4'(m), m, 3, m[0], $sformatf("mask%0d", m));

    // R8: page overflow
    run_stored(4'b1111, 5, 8, 1'b0, "ovf_a");
    run_stored(4'b1111, 7, 12, 1'b1, "ovf_b");

    // R3: blocking on an enabled stream without data
    load(4'b0011, 3, 4);
    flen[1] = 0;
    stall_on = 0;
    clear_capture();
    rdo_en = 1'b1; step(); rdo_en = 1'b0;
    step(40);
    chk(stream_addr == 4'd1 && rd_req, "R3 waits on empty stream", {stream_addr, rd_req}, 5'h3);
    chk(dn_cnt == 0, "R3 no completion while blocked", dn_cnt, 0);
    flen[1] = 1 + ((1 * 3 + 3) % 4);
    wait_done();
    expect_event("blocked");

    // R10: not-sample-all with no free page drains but stores nothing
    sample_all = 1'b0; page_free = 1'b0;
    load(4'b1011, 9, 4);
    clear_capture();
    rdo_en = 1'b1; step(); rdo_en = 1'b0;
    step(60);
    chk(wr_cnt == 0 && st_cnt == 0 && dn_cnt == 0, "R10 unstored event silent",
        wr_cnt + st_cnt + dn_cnt, 0);
    chk(fptr[0] == flen[0] && fptr[1] == flen[1] && fptr[3] == flen[3] && fptr[2] == 0,
        "R10 unstored event drained", fptr[0], flen[0]);
    exp_ev++;
    page_free = 1'b1;
    run_stored(4'b0110, 2, 3, 1'b0, "after_unstored R10");

    // R9: sample-all waits for a page
    sample_all = 1'b1; page_free = 1'b0;
    load(4'b1101, 4, 3);
    clear_capture();
    rdo_en = 1'b1;
    step(30);
    chk(rdq_cnt == 0 && st_cnt == 0, "R9 held while no page", rdq_cnt + st_cnt, 0);
    chk(fptr[0] == 0 && fptr[2] == 0 && fptr[3] == 0, "R9 nothing drained", fptr[0], 0);
    page_free = 1'b1;
    step();
    rdo_en = 1'b0;
    wait_done();
    expect_event("sample_all R9");
    sample_all = 1'b0;

    // R12: reset in the middle of an event
    load(4'b0011, 1, 3);
    flen[1] = 0;
    clear_capture();
    rdo_en = 1'b1; step(); rdo_en = 1'b0;
    step(10);
    rst_n = 1'b0;
    step(2);
    chk(stream_addr == 4'd0 && !rd_req, "R12 reset abandons event", {stream_addr, rd_req}, 0);
    rst_n = 1'b1;
    exp_ev = 0; exp_err = 0;
    step(2);
    chk(rdq_cnt <= 12 && !rd_req, "R12 idle after reset", rd_req, 0);
    run_stored(4'b0101, 1, 3, 1'b0, "post_reset R12");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule